// File: doc/BRIEF.md
# Receive Destination Address Filter with Multicast Hash

The block sits beside an Ethernet receive path and decides, for every incoming frame, whether the frame is kept. The MAC feeds the six destination-address bytes of a frame as a byte stream, marking the first with a start-of-frame pulse. While the bytes arrive, the block builds a CRC over them. It also compares the address with the programmed station address and classifies it as broadcast, group (multicast) or individual.

One cycle after the sixth byte, the block presents a registered decision. The decision holds the accept bit, the three match flags and the six-bit hash bin used for group addresses. Four enable bits, given on `cfg_i`, select which classes of frame are accepted. Software loads the station address and a 64-bin group hash table through a small word-wide write port.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, `dec_valid_o`, `accept_o`, `bcast_o`, `phys_o`, `mcast_o` and `hash_idx_o` are all zero, and the station address and hash table registers are zero.
- R2: Writes through the register port use these selectors:
  - `wr_addr_i`=0 loads station address bytes 0..3, with byte 0 in bits 7:0 and byte 3 in bits 31:24.
  - `wr_addr_i`=1 loads bytes 4 and 5 from bits 7:0 and 15:8. Bits 31:16 are dropped.
  - `wr_addr_i`=2 loads hash bins 0..31, with bin n in bit n.
  - `wr_addr_i`=3 loads bins 32..63, with bin 32+n in bit n.
- R3: `hash_idx_o` equals bits 31:26 of a CRC over the six destination bytes in arrival order. The CRC starts at all ones and has no final inversion. Each byte is taken LSB first, one bit per step: the feedback is CRC bit 31 XOR the data bit, the CRC shifts left one place, and a set feedback XORs in 0x04C11DB6 and then sets bit 0.
- R4: `bcast_o` is 1 exactly when all 48 destination bits are ones.
- R5: `mcast_o` is 1 exactly when bit 0 of destination byte 0 is set and the address is not broadcast.
- R6: `phys_o` is 1 exactly when the destination address equals the programmed station address.
- R7: `accept_o` is computed from the `cfg_i` bits sampled with the sixth byte. It is 1 when any one of these holds:
  - bit 0 (accept all) is set;
  - bit 1 is set and `phys_o` is 1;
  - bit 2 is set, `mcast_o` is 1 and the hash bin at `hash_idx_o` is set;
  - bit 3 is set and `bcast_o` is 1.
- R8: `dec_valid_o` pulses high for one cycle, in the cycle after the sixth byte is accepted with `byte_valid_i` high. Cycles with `byte_valid_i` low between bytes are skipped. The result outputs hold their values until the next decision.
- R9: `sof_i` restarts address capture and the CRC. A byte presented in the same cycle as `sof_i` is byte 0 of the new address, and a partly received address is discarded.
- R10: Bytes after the sixth and before the next `sof_i` are ignored. No decision is made and all result outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register selector (see R2) |
| wr_data_i | input | 32 | Register write data |
| cfg_i | input | 4 | Accept enables: all, physical, multicast, broadcast |
| sof_i | input | 1 | Start of frame, restarts capture |
| byte_valid_i | input | 1 | Address byte strobe |
| byte_i | input | 8 | Destination address byte |
| dec_valid_o | output | 1 | Decision pulse |
| accept_o | output | 1 | Frame accepted |
| bcast_o | output | 1 | Broadcast destination |
| phys_o | output | 1 | Station address matched |
| mcast_o | output | 1 | Group destination, not broadcast |
| hash_idx_o | output | 6 | Hash bin of the destination |

## Verification
A corrupted CRC register, or a wrong bit order in its update, shows in `hash_idx_o` at the first decision after the error. It shows in `accept_o` only when a group frame is tested against a sparse hash table. That is why every random frame compares the hash bin against an independent bitwise model.

A byte counter that slips shows as a decision pulse one byte early or late, or as a missing pulse. A slip also corrupts the captured address and so breaks the physical match. Both effects appear within a single frame. Bytes that are wrongly kept after the sixth show as an extra pulse or as flags that change between decisions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned HASH_W     = 6;
  localparam int unsigned HASH_BINS  = 1 << HASH_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB6;

  typedef enum logic [1:0] {
    SEL_STA_LO  = 2'd0,
    SEL_STA_HI  = 2'd1,
    SEL_HASH_LO = 2'd2,
    SEL_HASH_HI = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              accept;
    logic              bcast;
    logic              phys;
    logic              mcast;
    logic [HASH_W-1:0] hash_idx;
  } rxf_result_t;

  // Bit-serial LSB-first update; feedback sets bit 0 after the polynomial XOR
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = (c ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [31:0]          wr_data_i,
  output logic [ADDR_W-1:0]    station_o,
  output logic [HASH_BINS-1:0] hash_tbl_o
);
  localparam int unsigned HWORDS = HASH_BINS / 32;

  logic [31:0] sta_lo_q;
  logic [15:0] sta_hi_q;
  logic [31:0] hash_q [HWORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
    end else if (wr_en_i) begin
      if (reg_sel_e'(wr_addr_i) == SEL_STA_LO) sta_lo_q <= wr_data_i;
      if (reg_sel_e'(wr_addr_i) == SEL_STA_HI) sta_hi_q <= wr_data_i[15:0];
    end
  end

  for (genvar w = 0; w < HWORDS; w++) begin : g_hash
    localparam logic [1:0] SEL = 2'(int'(SEL_HASH_LO) + w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             hash_q[w] <= '0;
      else if (wr_en_i && wr_addr_i == SEL)    hash_q[w] <= wr_data_i;
    end
    assign hash_tbl_o[32*w +: 32] = hash_q[w];
  end

  assign station_o = {sta_hi_q, sta_lo_q};
endmodule

// File: rtl/rxf_crc.sv
module rxf_crc
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              last_o,
  output logic [CRC_W-1:0]  crc_nx_o,
  output logic [ADDR_W-1:0] addr_nx_o
);
  localparam int unsigned CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(ADDR_BYTES);

  logic [CW-1:0]     cnt_q, cnt_base, cnt_nx;
  logic [CRC_W-1:0]  crc_q, crc_base;
  logic [ADDR_W-1:0] addr_q;
  logic              take;

  always_comb begin
    cnt_base  = sof_i ? '0 : cnt_q;
    crc_base  = sof_i ? '1 : crc_q;
    take      = byte_valid_i && (cnt_base != CNT_DONE);
    cnt_nx    = take ? cnt_base + 1'b1 : cnt_base;
    crc_nx_o  = take ? crc_byte(crc_base, byte_i) : crc_base;
    addr_nx_o = addr_q;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (take && cnt_base == CW'(k)) addr_nx_o[8*k +: 8] = byte_i;
    last_o    = take && (cnt_nx == CNT_DONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_DONE;
      crc_q  <= '1;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_nx;
      crc_q  <= crc_nx_o;
      addr_q <= addr_nx_o;
    end
  end

  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_DONE);
  a_r9_sof_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && !byte_valid_i |=> cnt_q == '0 && crc_q == '1);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CRC_W-1:0]     crc_i,
  input  logic [ADDR_W-1:0]    station_i,
  input  logic [HASH_BINS-1:0] hash_tbl_i,
  input  logic [3:0]           cfg_i,
  output rxf_result_t          res_o
);
  logic [HASH_W-1:0] idx;
  logic bc, mc, pm, hit;

  always_comb begin
    idx = crc_i[CRC_W-1 -: HASH_W];
    bc  = &addr_i;
    mc  = addr_i[0] && !bc;
    pm  = (addr_i == station_i);
    hit = hash_tbl_i[idx];
    res_o.hash_idx = idx;
    res_o.bcast    = bc;
    res_o.mcast    = mc;
    res_o.phys     = pm;
    res_o.accept   = cfg_i[0] | (cfg_i[1] & pm) | (cfg_i[2] & mc & hit) | (cfg_i[3] & bc);
  end
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [3:0]  cfg_i,
  input  logic        sof_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        dec_valid_o,
  output logic        accept_o,
  output logic        bcast_o,
  output logic        phys_o,
  output logic        mcast_o,
  output logic [5:0]  hash_idx_o
);
  logic [ADDR_W-1:0]    station, addr_nx;
  logic [HASH_BINS-1:0] hash_tbl;
  logic [CRC_W-1:0]     crc_nx;
  logic                 last;
  rxf_result_t          res, res_q;
  logic                 dv_q;

  rxf_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .station_o(station), .hash_tbl_o(hash_tbl)
  );

  rxf_crc u_crc (
    .clk_i, .rst_ni, .sof_i, .byte_valid_i, .byte_i,
    .last_o(last), .crc_nx_o(crc_nx), .addr_nx_o(addr_nx)
  );

  rxf_decide u_dec (
    .addr_i(addr_nx), .crc_i(crc_nx), .station_i(station),
    .hash_tbl_i(hash_tbl), .cfg_i, .res_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q  <= 1'b0;
      res_q <= '0;
    end else begin
      dv_q <= last;
      if (last) res_q <= res;
    end
  end

  assign dec_valid_o = dv_q;
  assign accept_o    = res_q.accept;
  assign bcast_o     = res_q.bcast;
  assign phys_o      = res_q.phys;
  assign mcast_o     = res_q.mcast;
  assign hash_idx_o  = res_q.hash_idx;

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);
  a_r8_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_valid_o) |-> $past(byte_valid_i));
  a_r5_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bcast_o && mcast_o));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> $stable(accept_o) && $stable(hash_idx_o) && $stable(phys_o));
  a_r7_accept_reason: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && accept_o |-> $past(cfg_i[0]) || ($past(cfg_i[1]) && phys_o) ||
                                ($past(cfg_i[2]) && mcast_o) || ($past(cfg_i[3]) && bcast_o));
endmodule

// File: tb/tb_rxf_addr_filter.sv
module tb_rxf_addr_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0; logic [1:0] wr_addr = 0; logic [31:0] wr_data = 0;
  logic [3:0] cfg = 0; logic sof = 0, bv = 0; logic [7:0] bdat = 0;
  logic dv, acc, bc, ph, mc; logic [5:0] hidx;

  int checks = 0, fails = 0;
  logic [47:0] sta;
  logic [63:0] tbl;

  always #2 clk = ~clk;

  rxf_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cfg_i(cfg), .sof_i(sof), .byte_valid_i(bv), .byte_i(bdat),
    .dec_valid_o(dv), .accept_o(acc), .bcast_o(bc), .phys_o(ph), .mcast_o(mc), .hash_idx_o(hidx)
  );

  function automatic logic [5:0] m_hash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF; logic fb;
    for (int b = 0; b < 48; b++) begin
      fb = c[31] ^ a[b];
      c = c << 1;
      if (fb) c = (c ^ 32'h04C11DB6) | 32'h1;
    end
    return c[31:26];
  endfunction

  function automatic logic [3:0] m_flags(input logic [47:0] a, input logic [3:0] cf);
    logic b, m, p, h;
    b = (a == '1); m = a[0] && !b; p = (a == sta); h = tbl[m_hash(a)];
    return {cf[0] | (cf[1] & p) | (cf[2] & m & h) | (cf[3] & b), b, p, m};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_sta(input logic [47:0] s);
    wr(2'd0, s[31:0]); wr(2'd1, {16'hABCD, s[47:32]}); sta = s;
  endtask

  task automatic set_tbl(input logic [63:0] t);
    wr(2'd2, t[31:0]); wr(2'd3, t[63:32]); tbl = t;
  endtask

  task automatic send(input logic [47:0] a, input logic [3:0] cf, input bit gaps);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (gaps && ($urandom % 2 == 1)) begin
        sof = 0; bv = 0; @(negedge clk);
      end
      sof = (k == 0); bv = 1; bdat = a[8*k +: 8]; cfg = cf;
    end
    @(negedge clk); sof = 0; bv = 0; cfg = ~cf;
  endtask

  task automatic check_dec(input string tag, input logic [47:0] a, input logic [3:0] cf);
    logic [3:0] e; e = m_flags(a, cf);
    chk({tag, " R8 dec_valid"}, 64'(dv), 64'd1);
    chk({tag, " R3 hash"}, 64'(hidx), 64'(m_hash(a)));
    chk({tag, " R7 accept"}, 64'(acc), 64'(e[3]));
    chk({tag, " R4 bcast"}, 64'(bc), 64'(e[2]));
    chk({tag, " R6 phys"}, 64'(ph), 64'(e[1]));
    chk({tag, " R5 mcast"}, 64'(mc), 64'(e[0]));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] a; logic [3:0] cf; logic [5:0] h0, h1;
    void'($urandom(32'd1234));
    sta = '0; tbl = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset dec_valid", 64'(dv), 0);
    chk("R1 reset flags", 64'({acc, bc, ph, mc}), 0);
    chk("R1 reset hash", 64'(hidx), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 station reset to zero: all-zero address matches
    send(48'h0, 4'b0010, 0); check_dec("R1 zero station", 48'h0, 4'b0010);

    set_sta(48'h5544_3322_1100 | 48'h02);
    // R2 station layout / R6 match
    send(sta, 4'b0010, 0); check_dec("R2 station", sta, 4'b0010);
    chk("R2 phys set", 64'(ph), 1);
    a = sta ^ 48'h0100_0000_0000;
    send(a, 4'b0010, 0); check_dec("R6 mismatch", a, 4'b0010);
    chk("R6 phys clear", 64'(ph), 0);

    // R4 broadcast with enable off then on
    send('1, 4'b0110, 0); check_dec("R4 bc off", '1, 4'b0110);
    chk("R4 bc reject", 64'(acc), 0);
    send('1, 4'b1000, 1); check_dec("R4 bc on", '1, 4'b1000);
    chk("R4 bc accept", 64'(acc), 1);

    // R2/R7 hash: only the bin of a group address, in the high word
    a = 48'h0000_0000_0033;
    h0 = m_hash(a);
    while (h0 < 32) begin a = a + 48'h0100; h0 = m_hash(a); end
    set_tbl(64'(1) << h0);
    send(a, 4'b0100, 0); check_dec("R2 hash hi bin", a, 4'b0100);
    chk("R7 mc hit accept", 64'(acc), 1);
    a = 48'h0000_0000_0077;
    h1 = m_hash(a);
    while (h1 == h0) begin a = a + 48'h0100; h1 = m_hash(a); end
    send(a, 4'b0100, 0); check_dec("R7 mc miss", a, 4'b0100);
    chk("R7 mc miss reject", 64'(acc), 0);
    send(a, 4'b0001, 0); check_dec("R7 promisc", a, 4'b0001);
    chk("R7 promisc accept", 64'(acc), 1);

    // R8 pulse is one cycle, results hold
    @(negedge clk);
    chk("R8 pulse ends", 64'(dv), 0);
    chk("R8 hold accept", 64'(acc), 1);

    // R10 extra bytes ignored
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); bv = 1; bdat = 8'hFF; cfg = 4'hF;
    end
    @(negedge clk); bv = 0;
    chk("R10 no decision", 64'(dv), 0);
    chk("R10 flags unchanged", 64'({acc, bc, ph, mc, hidx}), 64'({1'b1, 1'b0, 1'b0, 1'b1, h1}));

    // R9 sof mid-address discards partial bytes
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sof = (k == 0); bv = 1; bdat = 8'hEE;
    end
    send(sta, 4'b0010, 0); check_dec("R9 restart", sta, 4'b0010);
    chk("R9 restart phys", 64'(ph), 1);

    // R3..R7 random frames against bench model
    for (int n = 0; n < 250; n++) begin
      if (n % 50 == 0) set_tbl({$urandom, $urandom});
      case ($urandom % 8)
        0: a = sta;
        1: a = '1;
        default: a = {16'($urandom), $urandom};
      endcase
      cf = 4'($urandom);
      send(a, cf, n % 3 == 0);
      check_dec("rand", a, cf);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule